// File: doc/BRIEF.md
# Parallel Page-Table Group Matcher

This block resolves one address translation against a page-table group that has already been fetched from memory. The group is a 1024-bit word: a 64-bit header in the low bits, followed by six 160-bit translation entries. All six entries are compared against the lookup key in the same cycle. The key is a 52-bit virtual page number plus an 8-bit address space identifier. The block reports whether a translation was found, which entry supplied it, that entry's 52-bit physical page number and its eight user access flags, and whether more than one entry claimed the key.

Each entry is five 32-bit words, counted from its low end:
- word 0 is the control word;
- words 1 and 2 carry the physical page number;
- words 3 and 4 carry the virtual page number.

A lookup is presented with a request strobe. With the default output register stage, the result appears one clock later together with a response strobe. With the stage disabled by parameter, the result follows the inputs combinationally. Hashing, probing and fetching the group are done elsewhere.

Top module: `ptgMatcher`

## Requirements
- R1: Entry i (0..5) occupies group bits [64+160*i +: 160]. Inside an entry, word 1 holds PPN[31:0] and word 2 bits [19:0] hold PPN[51:32]. Word 3 holds VPN[31:0] and word 4 bits [19:0] hold VPN[51:32]. The header bits [63:0], the upper 12 bits of words 2 and 4, and control bits [21:8] have no effect on any output.
- R2: An entry can match only when its valid bit (control bit 23) is 1.
- R3: A match requires all 52 bits of the stored virtual page number to equal the lookup VPN.
- R4: A match requires the entry's ASID (control bits [31:24]) to equal the lookup ASID, unless the entry's global bit (control bit 22) is 1. In that case the ASID is not compared.
- R5: During a response, hit is 1 when at least one entry matches. hitIdx is then the lowest-numbered matching entry.
- R6: multiHit is 1 exactly when two or more entries match during a response.
- R7: On a hit, ppn is the selected entry's physical page number. accessFlags is that entry's control bits [7:0], in the order D,U,S,A,C,R,W,X from bit 7 down to bit 0.
- R8: When there is no hit, or no response, the outputs hit, multiHit, hitIdx, ppn and accessFlags are all 0.
- R9: With OUT_REG=1, respValid and all results reflect the inputs sampled at the previous rising clock edge. They hold steady between edges. With OUT_REG=0 they follow the current inputs.
- R10: An active-low reset clears respValid and all result outputs to 0 at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | A lookup is presented this cycle |
| group | input | 1024 | Page-table group: header plus six entries |
| lookupVpn | input | 52 | Virtual page number to translate |
| lookupAsid | input | 8 | Address space identifier of the lookup |
| respValid | output | 1 | Result outputs belong to a lookup |
| hit | output | 1 | A matching entry was found |
| multiHit | output | 1 | More than one entry matched |
| hitIdx | output | 3 | Index of the winning entry |
| ppn | output | 52 | Physical page number of the winning entry |
| accessFlags | output | 8 | User access flags of the winning entry |

## Verification
With the default register stage, every result and respValid is due one rising edge after the lookup is sampled. The bench therefore drives inputs on a falling edge, waits for the next rising edge, and samples 1 time unit after it. Latency is checked directly: just after new inputs are driven, before the next rising edge, the bench confirms that the outputs still show the previous result. Reset clearing is checked asynchronously, with no clock edge in between.

// File: rtl/ptgPkg.sv
package ptgPkg;

  // Strobes passed from control to datapath
  typedef struct packed {
    logic capture;  // load a fresh result
    logic clear;    // force results to zero
  } ptgStrobes_t;

endpackage

// File: rtl/ptgEntryCmp.sv
module ptgEntryCmp #(
  parameter int ENTRY_W = 160,
  parameter int WORD_W  = 32,
  parameter int VPN_W   = 52,
  parameter int ASID_W  = 8,
  parameter int FLAG_W  = 8
) (
  input  logic [ENTRY_W-1:0] entry,
  input  logic [VPN_W-1:0]   lookupVpn,
  input  logic [ASID_W-1:0]  lookupAsid,
  output logic               isMatch,
  output logic [VPN_W-1:0]   entryPpn,
  output logic [FLAG_W-1:0]  entryFlags
);
  localparam int HI_W       = VPN_W - WORD_W;
  localparam int VALID_POS  = WORD_W - ASID_W - 1;
  localparam int GLOBAL_POS = VALID_POS - 1;
  localparam int PPN_LO     = 1 * WORD_W;
  localparam int PPN_HI     = 2 * WORD_W;
  localparam int VPN_LO     = 3 * WORD_W;
  localparam int VPN_HI     = 4 * WORD_W;

  logic [ASID_W-1:0] entryAsid;
  logic              entryValid;
  logic              entryGlobal;
  logic [VPN_W-1:0]  entryVpn;
  logic              vpnEq;
  logic              asidOk;

  assign entryAsid   = entry[WORD_W-1 -: ASID_W];
  assign entryValid  = entry[VALID_POS];
  assign entryGlobal = entry[GLOBAL_POS];
  assign entryVpn    = {entry[VPN_HI +: HI_W], entry[VPN_LO +: WORD_W]};
  assign entryPpn    = {entry[PPN_HI +: HI_W], entry[PPN_LO +: WORD_W]};
  assign entryFlags  = entry[FLAG_W-1:0];

  assign vpnEq   = (entryVpn == lookupVpn);
  assign asidOk  = entryGlobal | (entryAsid == lookupAsid);
  assign isMatch = entryValid & vpnEq & asidOk;

  // Fields with no role in matching
  logic unusedFields;
  assign unusedFields = ^{entry[GLOBAL_POS-1:FLAG_W],
                          entry[PPN_HI+HI_W +: WORD_W-HI_W],
                          entry[VPN_HI+HI_W +: WORD_W-HI_W]};
endmodule

// File: rtl/ptgDatapath.sv
module ptgDatapath
  import ptgPkg::*;
#(
  parameter int NUM_ENTRIES = 6,
  parameter int ENTRY_W     = 160,
  parameter int HDR_W       = 64,
  parameter int GROUP_W     = 1024,
  parameter int VPN_W       = 52,
  parameter int ASID_W      = 8,
  parameter int FLAG_W      = 8,
  parameter int IDX_W       = 3,
  parameter bit OUT_REG     = 1'b1
) (
  input  logic               clk,
  input  logic               rstN,
  input  ptgStrobes_t        strobes,
  input  logic [GROUP_W-1:0] group,
  input  logic [VPN_W-1:0]   lookupVpn,
  input  logic [ASID_W-1:0]  lookupAsid,
  output logic               hit,
  output logic               multiHit,
  output logic [IDX_W-1:0]   hitIdx,
  output logic [VPN_W-1:0]   ppn,
  output logic [FLAG_W-1:0]  accessFlags
);
  localparam int USED_W = HDR_W + NUM_ENTRIES * ENTRY_W;

  logic [NUM_ENTRIES-1:0] matchVec;
  logic [VPN_W-1:0]       ppnArr   [NUM_ENTRIES];
  logic [FLAG_W-1:0]      flagsArr [NUM_ENTRIES];

  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_cmp
    ptgEntryCmp #(
      .ENTRY_W(ENTRY_W), .VPN_W(VPN_W), .ASID_W(ASID_W), .FLAG_W(FLAG_W)
    ) u_cmp (
      .entry     (group[HDR_W + e*ENTRY_W +: ENTRY_W]),
      .lookupVpn (lookupVpn),
      .lookupAsid(lookupAsid),
      .isMatch   (matchVec[e]),
      .entryPpn  (ppnArr[e]),
      .entryFlags(flagsArr[e])
    );
  end

  // Lowest index wins; any later match marks a multi-hit
  logic              selFound;
  logic              selMulti;
  logic [IDX_W-1:0]  selIdx;
  logic [VPN_W-1:0]  selPpn;
  logic [FLAG_W-1:0] selFlags;

  always_comb begin
    selFound = 1'b0;
    selMulti = 1'b0;
    selIdx   = '0;
    selPpn   = '0;
    selFlags = '0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (matchVec[i]) begin
        if (selFound) begin
          selMulti = 1'b1;
        end else begin
          selFound = 1'b1;
          selIdx   = IDX_W'(i);
          selPpn   = ppnArr[i];
          selFlags = flagsArr[i];
        end
      end
    end
  end

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        hit         <= 1'b0;
        multiHit    <= 1'b0;
        hitIdx      <= '0;
        ppn         <= '0;
        accessFlags <= '0;
      end else if (strobes.capture) begin
        hit         <= selFound;
        multiHit    <= selMulti;
        hitIdx      <= selIdx;
        ppn         <= selPpn;
        accessFlags <= selFlags;
      end else if (strobes.clear) begin
        hit         <= 1'b0;
        multiHit    <= 1'b0;
        hitIdx      <= '0;
        ppn         <= '0;
        accessFlags <= '0;
      end
    end
  end else begin : g_comb
    logic gate;
    assign gate        = strobes.capture & ~strobes.clear;
    assign hit         = gate & selFound;
    assign multiHit    = gate & selMulti;
    assign hitIdx      = gate ? selIdx   : '0;
    assign ppn         = gate ? selPpn   : '0;
    assign accessFlags = gate ? selFlags : '0;
    logic unusedClk;
    assign unusedClk = clk ^ rstN;
  end

  // Header and any padding above the last entry carry no match data
  logic unusedHdr;
  if (USED_W < GROUP_W) begin : g_pad
    assign unusedHdr = ^{group[GROUP_W-1:USED_W], group[HDR_W-1:0]};
  end else begin : g_nopad
    assign unusedHdr = ^group[HDR_W-1:0];
  end
endmodule

// File: rtl/ptgControl.sv
module ptgControl
  import ptgPkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  output ptgStrobes_t strobes,
  output logic        respValid
);
  assign strobes.capture = reqValid;
  assign strobes.clear   = ~reqValid;

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) respValid <= 1'b0;
      else       respValid <= reqValid;
    end
  end else begin : g_comb
    assign respValid = reqValid;
    logic unusedClk;
    assign unusedClk = clk ^ rstN;
  end
endmodule

// File: rtl/ptgMatcher.sv
module ptgMatcher
  import ptgPkg::*;
#(
  parameter int NUM_ENTRIES = 6,
  parameter int ENTRY_W     = 160,
  parameter int HDR_W       = 64,
  parameter int GROUP_W     = 1024,
  parameter int VPN_W       = 52,
  parameter int ASID_W      = 8,
  parameter int FLAG_W      = 8,
  parameter bit OUT_REG     = 1'b1,
  localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic [GROUP_W-1:0] group,
  input  logic [VPN_W-1:0]   lookupVpn,
  input  logic [ASID_W-1:0]  lookupAsid,
  output logic               respValid,
  output logic               hit,
  output logic               multiHit,
  output logic [IDX_W-1:0]   hitIdx,
  output logic [VPN_W-1:0]   ppn,
  output logic [FLAG_W-1:0]  accessFlags
);
  ptgStrobes_t strobes;

  ptgControl #(.OUT_REG(OUT_REG)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .strobes  (strobes),
    .respValid(respValid)
  );

  ptgDatapath #(
    .NUM_ENTRIES(NUM_ENTRIES), .ENTRY_W(ENTRY_W), .HDR_W(HDR_W),
    .GROUP_W(GROUP_W), .VPN_W(VPN_W), .ASID_W(ASID_W), .FLAG_W(FLAG_W),
    .IDX_W(IDX_W), .OUT_REG(OUT_REG)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .group      (group),
    .lookupVpn  (lookupVpn),
    .lookupAsid (lookupAsid),
    .hit        (hit),
    .multiHit   (multiHit),
    .hitIdx     (hitIdx),
    .ppn        (ppn),
    .accessFlags(accessFlags)
  );
endmodule

// File: rtl/ptgMatcherChecker.sv
module ptgMatcherChecker #(
  parameter int NUM_ENTRIES = 6,
  parameter int ENTRY_W     = 160,
  parameter int HDR_W       = 64,
  parameter int GROUP_W     = 1024,
  parameter int VPN_W       = 52,
  parameter int ASID_W      = 8,
  parameter int FLAG_W      = 8,
  parameter bit OUT_REG     = 1'b1,
  parameter int IDX_W       = 3
) (
  input logic               clk,
  input logic               rstN,
  input logic               reqValid,
  input logic [GROUP_W-1:0] group,
  input logic [VPN_W-1:0]   lookupVpn,
  input logic [ASID_W-1:0]  lookupAsid,
  input logic               respValid,
  input logic               hit,
  input logic               multiHit,
  input logic [IDX_W-1:0]   hitIdx,
  input logic [VPN_W-1:0]   ppn,
  input logic [FLAG_W-1:0]  accessFlags
);
  localparam int WORD_W = 32;
  localparam int HI_W   = VPN_W - WORD_W;

  // Inputs that the current outputs belong to
  logic [GROUP_W-1:0] refGroup;
  logic [VPN_W-1:0]   refVpn;
  logic [ASID_W-1:0]  refAsid;
  logic               armed;

  if (OUT_REG) begin : g_ref
    always_ff @(posedge clk) begin
      refGroup <= group;
      refVpn   <= lookupVpn;
      refAsid  <= lookupAsid;
    end
  end else begin : g_ref
    assign refGroup = group;
    assign refVpn   = lookupVpn;
    assign refAsid  = lookupAsid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  logic [ENTRY_W-1:0] selEntry;
  always_comb begin
    selEntry = '0;
    for (int i = 0; i < NUM_ENTRIES; i++)
      if (hitIdx == IDX_W'(i)) selEntry = refGroup[HDR_W + i*ENTRY_W +: ENTRY_W];
  end

  assert_resp_latency_R9: assert property (@(posedge clk) disable iff (!rstN)
    armed |-> (respValid == (OUT_REG ? $past(reqValid) : reqValid)));

  assert_quiet_on_miss_R8: assert property (@(posedge clk) disable iff (!rstN)
    !hit |-> (!multiHit && hitIdx == '0 && ppn == '0 && accessFlags == '0));

  assert_hit_needs_resp_R5: assert property (@(posedge clk) disable iff (!rstN)
    hit |-> (respValid && hitIdx < IDX_W'(NUM_ENTRIES)));

  assert_multi_implies_hit_R6: assert property (@(posedge clk) disable iff (!rstN)
    multiHit |-> hit);

  assert_hit_entry_valid_R2: assert property (@(posedge clk) disable iff (!rstN)
    (armed && hit) |-> selEntry[WORD_W-ASID_W-1]);

  assert_hit_vpn_equal_R3: assert property (@(posedge clk) disable iff (!rstN)
    (armed && hit) |-> ({selEntry[4*WORD_W +: HI_W], selEntry[3*WORD_W +: WORD_W]} == refVpn));

  assert_hit_asid_or_global_R4: assert property (@(posedge clk) disable iff (!rstN)
    (armed && hit) |-> (selEntry[WORD_W-ASID_W-2] || selEntry[WORD_W-1 -: ASID_W] == refAsid));

  assert_hit_payload_R7: assert property (@(posedge clk) disable iff (!rstN)
    (armed && hit) |-> (ppn == {selEntry[2*WORD_W +: HI_W], selEntry[WORD_W +: WORD_W]}
                        && accessFlags == selEntry[FLAG_W-1:0]));
endmodule

bind ptgMatcher ptgMatcherChecker #(
  .NUM_ENTRIES(NUM_ENTRIES), .ENTRY_W(ENTRY_W), .HDR_W(HDR_W), .GROUP_W(GROUP_W),
  .VPN_W(VPN_W), .ASID_W(ASID_W), .FLAG_W(FLAG_W), .OUT_REG(OUT_REG), .IDX_W(IDX_W)
) u_ptgMatcherChecker (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .group(group),
  .lookupVpn(lookupVpn), .lookupAsid(lookupAsid), .respValid(respValid),
  .hit(hit), .multiHit(multiHit), .hitIdx(hitIdx), .ppn(ppn),
  .accessFlags(accessFlags)
);

// File: tb/test_ptgMatcher.sv
`timescale 1ns/1ps
module test_ptgMatcher;
  localparam int CLK_PERIOD = 10;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic [1023:0] group = '0;
  logic [51:0]   lookupVpn = '0;
  logic [7:0]    lookupAsid = '0;
  logic          respValid, hit, multiHit;
  logic [2:0]    hitIdx;
  logic [51:0]   ppn;
  logic [7:0]    accessFlags;

  int checkCount = 0;
  int failCount  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ptgMatcher i_ptgMatcher (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .group(group),
    .lookupVpn(lookupVpn), .lookupAsid(lookupAsid), .respValid(respValid),
    .hit(hit), .multiHit(multiHit), .hitIdx(hitIdx), .ppn(ppn),
    .accessFlags(accessFlags)
  );

  function automatic logic [159:0] mkEntry(input logic [51:0] vpn, input logic [51:0] pp,
                                           input logic [7:0] asid, input logic v,
                                           input logic g, input logic [7:0] flags);
    logic [31:0] ctrl;
    ctrl = {asid, v, g, 4'h0, 2'b00, 8'h00, flags};
    return {12'h000, vpn[51:32], vpn[31:0], 12'h000, pp[51:32], pp[31:0], ctrl};
  endfunction

  task automatic putEntry(input int idx, input logic [159:0] e);
    group[64 + idx*160 +: 160] = e;
  endtask

  task automatic checkVal(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Drive on a falling edge, sample just after the next rising edge
  task automatic lookup(input logic [51:0] vpn, input logic [7:0] asid);
    @(negedge clk);
    reqValid   = 1'b1;
    lookupVpn  = vpn;
    lookupAsid = asid;
    @(posedge clk);
    #1;
  endtask

  task automatic expectResult(input string tag, input logic h, input logic m,
                              input logic [2:0] idx, input logic [51:0] pp,
                              input logic [7:0] fl);
    checkVal({tag, " respValid"}, 64'(respValid), 64'(1'b1));
    checkVal({tag, " hit"}, 64'(hit), 64'(h));
    checkVal({tag, " multiHit"}, 64'(multiHit), 64'(m));
    checkVal({tag, " hitIdx"}, 64'(hitIdx), 64'(idx));
    checkVal({tag, " ppn"}, 64'(ppn), 64'(pp));
    checkVal({tag, " flags"}, 64'(accessFlags), 64'(fl));
  endtask

  task automatic testReset;
    #1;
    checkVal("R10 reset respValid", 64'(respValid), 64'd0);
    checkVal("R10 reset hit", 64'(hit), 64'd0);
    checkVal("R10 reset ppn", 64'(ppn), 64'd0);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic testSingleHit;
    group = '0;
    putEntry(3, mkEntry(52'hA_BCDE_F012_3456, 52'h1_2345_6789_ABCD, 8'h42, 1, 0, 8'b0110_0110));
    putEntry(0, mkEntry(52'hA_BCDE_F012_3457, 52'h9, 8'h42, 1, 0, 8'hFF));
    lookup(52'hA_BCDE_F012_3456, 8'h42);
    expectResult("R5 R7 R1 single hit", 1, 0, 3'd3, 52'h1_2345_6789_ABCD, 8'b0110_0110);
  endtask

  task automatic testInvalid;
    group = '0;
    putEntry(2, mkEntry(52'h0_0000_0000_1000, 52'h77, 8'h05, 0, 0, 8'h0F));
    lookup(52'h0_0000_0000_1000, 8'h05);
    expectResult("R2 invalid entry", 0, 0, 3'd0, 52'h0, 8'h00);
  endtask

  task automatic testVpnBits;
    group = '0;
    putEntry(1, mkEntry(52'h0_0000_0000_2000, 52'h55, 8'h01, 1, 0, 8'h07));
    lookup(52'h8_0000_0000_2000, 8'h01);
    expectResult("R3 vpn bit51 differs", 0, 0, 3'd0, 52'h0, 8'h00);
    lookup(52'h0_0000_0000_2001, 8'h01);
    expectResult("R3 vpn bit0 differs", 0, 0, 3'd0, 52'h0, 8'h00);
    lookup(52'h0_0001_0000_2000, 8'h01);
    expectResult("R3 vpn bit32 differs", 0, 0, 3'd0, 52'h0, 8'h00);
    lookup(52'h0_0000_0000_2000, 8'h01);
    expectResult("R3 vpn equal", 1, 0, 3'd1, 52'h55, 8'h07);
  endtask

  task automatic testAsid;
    group = '0;
    putEntry(4, mkEntry(52'h3_0000_0000_0040, 52'hBEEF, 8'h10, 1, 0, 8'h81));
    lookup(52'h3_0000_0000_0040, 8'h11);
    expectResult("R4 asid mismatch", 0, 0, 3'd0, 52'h0, 8'h00);
    putEntry(4, mkEntry(52'h3_0000_0000_0040, 52'hBEEF, 8'h10, 1, 1, 8'h81));
    lookup(52'h3_0000_0000_0040, 8'h11);
    expectResult("R4 global ignores asid", 1, 0, 3'd4, 52'hBEEF, 8'h81);
  endtask

  task automatic testMulti;
    group = '0;
    putEntry(4, mkEntry(52'h5, 52'h444, 8'h09, 1, 0, 8'h44));
    putEntry(1, mkEntry(52'h5, 52'h111, 8'h09, 1, 0, 8'h11));
    lookup(52'h5, 8'h09);
    expectResult("R6 R5 two matches lowest wins", 1, 1, 3'd1, 52'h111, 8'h11);
  endtask

  task automatic testIgnoredBits;
    group = '1;
    for (int i = 0; i < 6; i++) begin
      logic [159:0] e;
      e = mkEntry(52'hF_0000_0000_0000 + 52'(i), 52'h200 + 52'(i), 8'h33, 1, 0, 8'h20 + 8'(i));
      e[21:8]    = '1;
      e[95:84]   = '1;
      e[159:148] = '1;
      putEntry(i, e);
    end
    lookup(52'hF_0000_0000_0005, 8'h33);
    expectResult("R1 filler bits and header ignored, entry5", 1, 0, 3'd5, 52'h205, 8'h25);
  endtask

  task automatic testNoRequest;
    group = '0;
    putEntry(0, mkEntry(52'h7, 52'h70, 8'h01, 1, 0, 8'h3C));
    lookup(52'h7, 8'h01);
    expectResult("R5 entry0 hit", 1, 0, 3'd0, 52'h70, 8'h3C);
    @(negedge clk);
    reqValid = 1'b0;
    #1;
    checkVal("R9 holds before edge", 64'(hit), 64'd1);
    @(posedge clk);
    #1;
    checkVal("R8 R9 no request respValid", 64'(respValid), 64'd0);
    checkVal("R8 no request hit", 64'(hit), 64'd0);
    checkVal("R8 no request ppn", 64'(ppn), 64'd0);
    checkVal("R8 no request flags", 64'(accessFlags), 64'd0);
  endtask

  task automatic testMidReset;
    group = '0;
    putEntry(2, mkEntry(52'h99, 52'h990, 8'h02, 1, 0, 8'h01));
    lookup(52'h99, 8'h02);
    checkVal("R5 pre-reset hit", 64'(hit), 64'd1);
    #2;
    rstN = 1'b0;
    #1;
    checkVal("R10 async reset hit", 64'(hit), 64'd0);
    checkVal("R10 async reset respValid", 64'(respValid), 64'd0);
    checkVal("R10 async reset ppn", 64'(ppn), 64'd0);
    @(negedge clk);
    reqValid = 1'b0;
    rstN = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failCount++;
    checkCount++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end

  initial begin
    testReset();
    testSingleHit();
    testInvalid();
    testVpnBits();
    testAsid();
    testMulti();
    testIgnoredBits();
    testNoRequest();
    testMidReset();
    repeat (2) @(posedge clk);
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end
endmodule